// File: doc/BRIEF.md
# Serial Bootstrap Loader

After reset this block takes control of a serial receive line and decides what the processor should run, based on the first character it receives. A zero character, or a break, requests a jump to the start of nonvolatile memory. An all-ones character fixes the bit rate and starts a download. Every following byte is written into on-chip RAM, at addresses that start at zero and go up by one. The download has no fixed length. It ends when the receive line has carried no start bit for a set time. The block then requests a jump into RAM and reports how many bytes were stored.

At startup the transmit line sends one break character. If the transmit line is wired back to the receive line, this break selects the nonvolatile path without any outside help. Two bit rates are supported: a fast default rate and a slow rate of 1200 baud. The slow rate is selected when the first character seen at the fast rate is not one of the two command values. Bit timing is set by two clock-divider parameters.

Top module: `bootLoader`

## Requirements
- R1: A receive line held low from reset is never taken as a character or a break. Without a high-to-low transition, no jump is requested, nothing is written and `done` stays low.
- R2: If the first character is 0x00, whether its stop bit is high or it is a break, `jumpNv` pulses for one cycle and `done` goes high. No RAM write takes place and `byteCount` stays 0.
- R3: A first character of 0xFF with a valid stop bit starts the download. It is not written to RAM and does not change `byteCount`.
- R4: Each byte received with a valid stop bit during the download is written to RAM at the address equal to the number of bytes already stored, starting at 0. `byteCount` then rises by one.
- R5: During the download, once `IDLE_BITS` (40) bit periods have passed since the last start-bit edge, `jumpRam` pulses for exactly one cycle and `done` goes high. At 35 bit periods no pulse has yet occurred.
- R6: Before the 0xFF has been received, the idle timeout is not running, so any delay after reset is tolerated.
- R7: After reset, `txd` stays high for one fast bit period, then low for ten fast bit periods, then high. When `txd` is looped back to `rxd`, this break produces the `jumpNv` request.
- R8: A first character at the fast rate that is neither 0x00 nor 0xFF switches the receiver to the slow divider. The block then waits again for a first character, and the download then runs at the slow rate.
- R9: At most `RAM_DEPTH` (256) bytes are stored. Further bytes cause no write, and `byteCount` stays at 256.
- R10: Once `done` is high, activity on `rxd` causes no RAM write and no change to `byteCount` until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line; sends the startup break |
| ramWe | output | 1 | RAM write enable, one cycle per stored byte |
| ramAddr | output | 8 | RAM write address |
| ramData | output | 8 | RAM write data |
| byteCount | output | 9 | Number of bytes stored |
| jumpNv | output | 1 | One-cycle request to jump to nonvolatile memory |
| jumpRam | output | 1 | One-cycle request to jump to RAM |
| done | output | 1 | High once a jump has been requested |

## Verification
The bench holds the receive line low from reset. A receiver that treated the reset level as an edge would see a false break and request a jump. It waits a long time before sending 0xFF, which catches an idle timer that starts running at reset. It measures the timeout at 35 and at 45 bit periods, which exposes a timer that fires early or is never cleared by start edges. It sends 258 data bytes to test the 256-byte limit, which would show up as a wrapped address or an overflowing count. It also sends a non-command first character to check the switch to the slow rate, loops `txd` back to `rxd` to test the startup break, and checks that traffic after `done` writes nothing.

// File: rtl/bootPkg.sv
package bootPkg;
  typedef struct packed {
    logic setSlow;
    logic armIdle;
    logic writeByte;
  } ctrlStrobeT;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2
  } loadStateT;
endpackage

// File: rtl/bootDatapath.sv
module bootDatapath
  import bootPkg::*;
#(
  parameter int FAST_DIV  = 16,
  parameter int SLOW_DIV  = 64,
  parameter int RAM_DEPTH = 256,
  parameter int IDLE_BITS = 40,
  localparam int ADDR_W = $clog2(RAM_DEPTH),
  localparam int CNT_W  = $clog2(RAM_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxd,
  input  ctrlStrobeT        strobe,
  output logic              byteValid,
  output logic [7:0]        byteData,
  output logic              stopOk,
  output logic              idleExpired,
  output logic              txd,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData,
  output logic [CNT_W-1:0]  byteCount
);
  localparam int DIV_W  = $clog2(SLOW_DIV + 1);
  localparam int IDLE_W = $clog2(IDLE_BITS * SLOW_DIV + 1);
  localparam int TX_END = 11 * FAST_DIV;
  localparam int TX_W   = $clog2(TX_END + 1);

  logic             rxMeta, rxCur, rxPrev;
  logic             slowRate;
  logic [DIV_W-1:0] bitDiv;
  logic             rxBusy;
  logic [3:0]       bitIdx;
  logic [DIV_W-1:0] tick;
  logic             startEdge;
  logic [IDLE_W-1:0] idleCnt, idleLimit;
  logic [TX_W-1:0]  txCnt;

  assign bitDiv    = slowRate ? DIV_W'(SLOW_DIV) : DIV_W'(FAST_DIV);
  assign startEdge = !rxBusy && rxPrev && !rxCur;
  assign idleLimit = IDLE_W'(IDLE_BITS) * IDLE_W'(bitDiv) - IDLE_W'(1);
  assign idleExpired = strobe.armIdle && (idleCnt == idleLimit);

  // sync chain resets low so that a low line never yields a falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b0;
      rxCur  <= 1'b0;
      rxPrev <= 1'b0;
    end else begin
      rxMeta <= rxd;
      rxCur  <= rxMeta;
      rxPrev <= rxCur;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slowRate <= 1'b0;
    else if (strobe.setSlow) slowRate <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBusy    <= 1'b0;
      bitIdx    <= '0;
      tick      <= '0;
      byteData  <= '0;
      stopOk    <= 1'b0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      if (!rxBusy) begin
        if (startEdge) begin
          rxBusy <= 1'b1;
          bitIdx <= '0;
          tick   <= (bitDiv >> 1) - DIV_W'(1);
        end
      end else if (tick != '0) begin
        tick <= tick - DIV_W'(1);
      end else begin
        tick   <= bitDiv - DIV_W'(1);
        bitIdx <= bitIdx + 4'd1;
        if (bitIdx == 4'd0) begin
          if (rxCur) rxBusy <= 1'b0;
        end else if (bitIdx <= 4'd8) begin
          byteData <= {rxCur, byteData[7:1]};
        end else begin
          rxBusy    <= 1'b0;
          stopOk    <= rxCur;
          byteValid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idleCnt <= '0;
    else if (!strobe.armIdle || startEdge) idleCnt <= '0;
    else if (idleCnt != idleLimit) idleCnt <= idleCnt + IDLE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramWe     <= 1'b0;
      ramAddr   <= '0;
      ramData   <= '0;
      byteCount <= '0;
    end else begin
      ramWe <= 1'b0;
      if (strobe.writeByte && (byteCount != CNT_W'(RAM_DEPTH))) begin
        ramWe     <= 1'b1;
        ramAddr   <= byteCount[ADDR_W-1:0];
        ramData   <= byteData;
        byteCount <= byteCount + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt <= '0;
      txd   <= 1'b1;
    end else begin
      if (txCnt != TX_W'(TX_END)) txCnt <= txCnt + TX_W'(1);
      txd <= !((txCnt >= TX_W'(FAST_DIV)) && (txCnt < TX_W'(TX_END)));
    end
  end
endmodule

// File: rtl/bootControl.sv
module bootControl
  import bootPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic       stopOk,
  input  logic       idleExpired,
  output ctrlStrobeT strobe,
  output logic       jumpNv,
  output logic       jumpRam,
  output logic       done
);
  loadStateT state;
  logic isZero, isOnes;

  assign isZero = byteData == 8'h00;
  assign isOnes = (byteData == 8'hFF) && stopOk;

  always_comb begin
    strobe.setSlow   = (state == ST_WAIT) && byteValid && !isZero && !isOnes;
    strobe.armIdle   = (state == ST_LOAD);
    strobe.writeByte = (state == ST_LOAD) && byteValid && stopOk;
  end

  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAIT;
      jumpNv  <= 1'b0;
      jumpRam <= 1'b0;
    end else begin
      jumpNv  <= 1'b0;
      jumpRam <= 1'b0;
      case (state)
        ST_WAIT: if (byteValid) begin
          if (isZero) begin
            jumpNv <= 1'b1;
            state  <= ST_DONE;
          end else if (isOnes) begin
            state <= ST_LOAD;
          end
        end
        ST_LOAD: if (idleExpired) begin
          jumpRam <= 1'b1;
          state   <= ST_DONE;
        end
        default: state <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/bootLoader.sv
module bootLoader
  import bootPkg::*;
#(
  parameter int FAST_DIV  = 16,
  parameter int SLOW_DIV  = 64,
  parameter int RAM_DEPTH = 256,
  parameter int IDLE_BITS = 40,
  localparam int ADDR_W = $clog2(RAM_DEPTH),
  localparam int CNT_W  = $clog2(RAM_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxd,
  output logic              txd,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData,
  output logic [CNT_W-1:0]  byteCount,
  output logic              jumpNv,
  output logic              jumpRam,
  output logic              done
);
  ctrlStrobeT strobe;
  logic       byteValid, stopOk, idleExpired;
  logic [7:0] byteData;

  bootDatapath #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV),
    .RAM_DEPTH(RAM_DEPTH), .IDLE_BITS(IDLE_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxd(rxd), .strobe(strobe),
    .byteValid(byteValid), .byteData(byteData), .stopOk(stopOk),
    .idleExpired(idleExpired), .txd(txd), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramData(ramData), .byteCount(byteCount)
  );

  bootControl u_ctl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .stopOk(stopOk), .idleExpired(idleExpired), .strobe(strobe),
    .jumpNv(jumpNv), .jumpRam(jumpRam), .done(done)
  );
endmodule

// File: rtl/bootLoaderChecker.sv
module bootLoaderChecker #(
  parameter int RAM_DEPTH = 256,
  parameter int CNT_W     = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             ramWe,
  input logic [CNT_W-1:0] byteCount,
  input logic             jumpNv,
  input logic             jumpRam,
  input logic             done
);
  a_r5_jump_ram_single: assert property (@(posedge clk) disable iff (!rstN)
    jumpRam |=> !jumpRam);

  a_r2_jumps_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(jumpRam && jumpNv));

  a_r2_nv_empty: assert property (@(posedge clk) disable iff (!rstN)
    jumpNv |-> (byteCount == '0));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= CNT_W'(RAM_DEPTH));

  a_r10_frozen: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ($stable(byteCount) && !ramWe));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWe) |-> (byteCount == $past(byteCount) + CNT_W'(1)));
endmodule

bind bootLoader bootLoaderChecker #(.RAM_DEPTH(RAM_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .ramWe(ramWe), .byteCount(byteCount),
  .jumpNv(jumpNv), .jumpRam(jumpRam), .done(done)
);

// File: tb/bootLoader_bench.sv
module bootLoader_bench;
  localparam int FAST = 16;
  localparam int SLOW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxDrv = 1'b1;
  logic loopBack = 1'b0;
  logic rxd, txd, ramWe, jumpNv, jumpRam, done;
  logic [7:0] ramAddr, ramData;
  logic [8:0] byteCount;

  int tests = 0;
  int fails = 0;
  int wrCnt, nvPulses, ramPulses;
  logic [7:0] img [256];

  always #2 clk = ~clk;
  assign rxd = loopBack ? txd : rxDrv;

  bootLoader u_bootLoader (
    .clk(clk), .rstN(rstN), .rxd(rxd), .txd(txd), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramData(ramData), .byteCount(byteCount),
    .jumpNv(jumpNv), .jumpRam(jumpRam), .done(done)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      wrCnt <= 0; nvPulses <= 0; ramPulses <= 0;
    end else begin
      if (ramWe) begin img[ramAddr] <= ramData; wrCnt <= wrCnt + 1; end
      if (jumpNv) nvPulses <= nvPulses + 1;
      if (jumpRam) ramPulses <= ramPulses + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic lineLevel, input logic loop);
    @(negedge clk);
    rstN = 1'b0; rxDrv = lineLevel; loopBack = loop;
    cyc(4);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic sendByte(input logic [7:0] d, input int div, input logic stopVal);
    rxDrv = 1'b0; cyc(div);
    for (int i = 0; i < 8; i++) begin rxDrv = d[i]; cyc(div); end
    rxDrv = stopVal; cyc(div);
    if (!stopVal) begin rxDrv = 1'b1; cyc(div); end
    rxDrv = 1'b1;
  endtask

  task automatic testResetState();
    doReset(1'b1, 1'b0);
    chk(byteCount == 0, "R4 reset count", byteCount, 0);
    chk(!done && !jumpNv && !jumpRam && !ramWe, "R1 reset outputs", done, 0);
    chk(txd == 1'b1, "R7 txd high after reset", txd, 1);
  endtask

  task automatic testTxBreak();
    doReset(1'b1, 1'b0);
    cyc(5 * FAST);
    chk(txd == 1'b0, "R7 txd low during break", txd, 0);
    cyc(8 * FAST);
    chk(txd == 1'b1, "R7 txd high after break", txd, 1);
  endtask

  task automatic testLoopBack();
    doReset(1'b1, 1'b1);
    cyc(20 * FAST);
    chk(nvPulses == 1, "R7 loopback nv jump", nvPulses, 1);
    chk(done && wrCnt == 0, "R7 loopback done no write", wrCnt, 0);
    loopBack = 1'b0;
  endtask

  task automatic testLowLine();
    doReset(1'b0, 1'b0);
    cyc(200 * FAST);
    chk(nvPulses == 0 && ramPulses == 0, "R1 low line no jump", nvPulses + ramPulses, 0);
    chk(!done && wrCnt == 0, "R1 low line no write", wrCnt, 0);
  endtask

  task automatic testZero(input logic stopVal);
    doReset(1'b1, 1'b0);
    sendByte(8'h00, FAST, stopVal);
    cyc(2 * FAST);
    chk(nvPulses == 1, "R2 zero or break nv jump", nvPulses, 1);
    chk(done && wrCnt == 0 && byteCount == 0, "R2 no download", byteCount, 0);
    chk(ramPulses == 0, "R2 no ram jump", ramPulses, 0);
  endtask

  task automatic testDownload();
    logic [7:0] pat [5] = '{8'h12, 8'hFF, 8'h00, 8'hA5, 8'h3C};
    doReset(1'b1, 1'b0);
    sendByte(8'hFF, FAST, 1'b1);
    cyc(5 * FAST);
    chk(wrCnt == 0 && byteCount == 0, "R3 FF not stored", byteCount, 0);
    for (int i = 0; i < 5; i++) sendByte(pat[i], FAST, 1'b1);
    chk(byteCount == 5 && wrCnt == 5, "R4 count after five", byteCount, 5);
    for (int i = 0; i < 5; i++)
      chk(img[i] == pat[i], "R4 image byte", img[i], pat[i]);
    cyc(25 * FAST);
    chk(ramPulses == 0 && !done, "R5 no early timeout", ramPulses, 0);
    cyc(10 * FAST);
    chk(ramPulses == 1 && done, "R5 timeout single pulse", ramPulses, 1);
    sendByte(8'h77, FAST, 1'b1);
    cyc(2 * FAST);
    chk(wrCnt == 5 && byteCount == 5, "R10 ignored after done", byteCount, 5);
    chk(ramPulses == 1 && nvPulses == 0, "R10 no further jump", ramPulses, 1);
  endtask

  task automatic testLongWait();
    doReset(1'b1, 1'b0);
    cyc(300 * FAST);
    chk(ramPulses == 0 && !done, "R6 no timeout before FF", ramPulses, 0);
    sendByte(8'hFF, FAST, 1'b1);
    sendByte(8'h81, FAST, 1'b1);
    sendByte(8'h42, FAST, 1'b1);
    cyc(35 * FAST);
    chk(ramPulses == 1 && byteCount == 2, "R6 download after delay", byteCount, 2);
  endtask

  task automatic testSlowRate();
    doReset(1'b1, 1'b0);
    sendByte(8'h55, FAST, 1'b1);
    cyc(2 * FAST);
    chk(!done && wrCnt == 0, "R8 unknown first char no action", wrCnt, 0);
    sendByte(8'hFF, SLOW, 1'b1);
    sendByte(8'hC3, SLOW, 1'b1);
    sendByte(8'h0F, SLOW, 1'b1);
    sendByte(8'hE1, SLOW, 1'b1);
    chk(byteCount == 3, "R8 slow count", byteCount, 3);
    chk(img[0] == 8'hC3 && img[1] == 8'h0F && img[2] == 8'hE1, "R8 slow data", img[2], 8'hE1);
    cyc(35 * SLOW);
    chk(ramPulses == 1, "R8 slow timeout", ramPulses, 1);
  endtask

  task automatic testFull();
    int bad = 0;
    doReset(1'b1, 1'b0);
    sendByte(8'hFF, FAST, 1'b1);
    for (int i = 0; i < 258; i++) sendByte(8'(i) ^ 8'h5A, FAST, 1'b1);
    chk(byteCount == 256, "R9 count saturates", byteCount, 256);
    chk(wrCnt == 256, "R9 write count", wrCnt, 256);
    for (int i = 0; i < 256; i++) if (img[i] != (8'(i) ^ 8'h5A)) bad++;
    chk(bad == 0, "R9 image contents", bad, 0);
    cyc(35 * FAST);
    chk(ramPulses == 1 && done, "R9 timeout after full", ramPulses, 1);
  endtask

  initial begin
    testResetState();
    testTxBreak();
    testLoopBack();
    testLowLine();
    testZero(1'b1);
    testZero(1'b0);
    testDownload();
    testLongWait();
    testSlowRate();
    testFull();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule